// File: doc/BRIEF.md
# Reference Lock Timeout Supervisor

This block watches a digital PLL's primary path while it tries to lock to one of fourteen reference inputs. When a reference is selected and the loop is not yet locked, a lock-attempt timer counts seconds. If the programmed number of seconds passes without lock, the block sets an alarm bit for that reference. The same bit reports the reference as not eligible for primary-path locking. The programmed period is a 6-bit count multiplied by a 2-bit factor.

Each alarm clears under one of two policies, picked by a configuration input. In the software policy, a write strobe with a one in the alarm's bit position clears it. In the self-clearing policy, every alarm ages on its own counter and drops once the programmed period has passed since it was raised. Time advances only on a single-cycle seconds strobe, so a bench can run with a fast tick.

Top module: `lock_alarm_supervisor`

## Requirements
- R1: With limit L = cfg_val × cfg_mul (non-zero), reference i selected (sel_valid=1, sel_idx=i) and pll_locked low, alarm[i] sets on the L-th sec_tick counted from the selection cycle. It is visible one clock after that tick.
- R2: pll_locked high stops and clears the attempt timer. A tick that would reach L in a cycle where pll_locked is high raises no alarm.
- R3: A new sel_idx value, or sel_valid rising, restarts the count from zero. Ticks spent on the previous reference do not count towards the new one.
- R4: A limit of zero (cfg_val=0 or cfg_mul=0) never raises an alarm.
- R5: Bit i of alarm and disq belongs to reference i (sel_idx=i). A timeout sets only the bit of the currently selected reference.
- R6: With cfg_auto_clr=0, clr_we high for one cycle clears alarm[i] wherever clr_mask[i]=1. Bits where clr_mask is 0 keep their value.
- R7: With cfg_auto_clr=1, an alarm clears on the L-th sec_tick after the cycle in which it was raised. Each reference ages independently.
- R8: With cfg_auto_clr=1, clr_we has no effect on any alarm bit.
- R9: disq[i] equals alarm[i] at all times.
- R10: After an alarm is raised, the attempt timer holds until the selection changes, sel_valid drops, or lock is seen. A cleared alarm is not raised again during the same attempt.
- R11: After reset, alarm and disq are all zero and the attempt timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe per second |
| sel_valid | input | 1 | A reference is currently selected |
| sel_idx | input | 4 | Index of the selected reference |
| pll_locked | input | 1 | Primary-path PLL lock indication |
| cfg_val | input | 6 | Timeout count |
| cfg_mul | input | 2 | Timeout multiplying factor |
| cfg_auto_clr | input | 1 | 1: alarms self-clear, 0: software clear |
| clr_we | input | 1 | Software clear strobe |
| clr_mask | input | 14 | Per-reference clear bits (1 = clear) |
| alarm | output | 14 | Per-reference lock-timeout alarm |
| disq | output | 14 | Per-reference disqualification flag |

## Verification
Directed runs select a reference and count ticks to the exact expiry edge. Three patterns are separated by this: a mid-attempt reselection, which must restart the count; lock arriving on the expiring tick, which must suppress the alarm; and a zero limit, which must never fire. The clearing policies are checked with masks that do and do not cover the alarmed bit. Two alarms with staggered raise times must drop at different ticks in self-clearing mode. A seeded random phase then changes selection, lock, configuration and clear strobes against a bench model, which catches interactions such as a policy switch while an alarm is ageing.

// File: rtl/lock_alarm_pkg.sv
package lock_alarm_pkg;

  // Timeout in seconds: count times multiplying factor
  function automatic int unsigned limit_of(input int unsigned val, input int unsigned mul);
    return val * mul;
  endfunction

  // True when one more second reaches or passes the limit
  function automatic logic hit_limit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/la_attempt_timer.sv
module la_attempt_timer #(
  parameter int SEL_W = 4,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             sel_valid,
  input  logic [SEL_W-1:0] sel_idx,
  input  logic             pll_locked,
  input  logic [LIM_W-1:0] limit,
  output logic             expire,
  output logic             restart
);
  logic [LIM_W-1:0] cnt_q, cnt_eff;
  logic             done_q, done_eff;
  logic             prev_valid_q;
  logic [SEL_W-1:0] prev_sel_q;
  logic             running;

  assign restart  = sel_valid && (!prev_valid_q || (sel_idx != prev_sel_q));
  assign cnt_eff  = restart ? '0 : cnt_q;
  assign done_eff = restart ? 1'b0 : done_q;
  assign running  = sel_valid && !pll_locked && !done_eff && (limit != '0);
  assign expire   = running && sec_tick &&
                    lock_alarm_pkg::hit_limit(32'(cnt_eff), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      done_q       <= 1'b0;
      prev_valid_q <= 1'b0;
      prev_sel_q   <= '0;
    end else begin
      prev_valid_q <= sel_valid;
      prev_sel_q   <= sel_idx;
      if (!sel_valid || pll_locked) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (expire) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else if (running && sec_tick) begin
        cnt_q  <= cnt_eff + LIM_W'(1);
        done_q <= done_eff;
      end else begin
        cnt_q  <= cnt_eff;
        done_q <= done_eff;
      end
    end
  end

  // R2: lock in the same cycle always wins over expiry
  a_r2_lock_blocks_expire: assert property (@(posedge clk) disable iff (!rst_n)
    pll_locked |-> !expire);

  // R4: zero limit never expires
  a_r4_zero_limit_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !expire);

  // R10: after expiry the timer holds while the selection is unchanged and unlocked
  a_r10_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    expire && sel_valid |=> (restart || !sel_valid || pll_locked || !expire));

endmodule

// File: rtl/la_alarm_cell.sv
module la_alarm_cell #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic [LIM_W-1:0] limit,
  input  logic             cfg_auto,
  input  logic             raise,
  input  logic             clr_hit,
  output logic             alarm
);
  logic             alarm_q;
  logic [LIM_W-1:0] age_q;
  logic             age_done;
  logic             sw_clear;

  assign age_done = alarm_q && cfg_auto && sec_tick &&
                    lock_alarm_pkg::hit_limit(32'(age_q), 32'(limit));
  assign sw_clear = alarm_q && !cfg_auto && clr_hit;
  assign alarm    = alarm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q <= 1'b0;
      age_q   <= '0;
    end else if (raise) begin
      alarm_q <= 1'b1;
      age_q   <= '0;
    end else if (age_done || sw_clear) begin
      alarm_q <= 1'b0;
    end else if (alarm_q && cfg_auto && sec_tick) begin
      age_q   <= age_q + LIM_W'(1);
    end
  end

  // R1: an alarm only appears after a raise event
  a_r1_rise_needs_raise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> $past(raise));

  // R6: software clear in manual policy takes effect next cycle
  a_r6_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q && !cfg_auto && clr_hit && !raise |=> !alarm_q);

  // R8: clear strobe ignored under the self-clearing policy
  a_r8_auto_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q && cfg_auto && clr_hit && !sec_tick |=> alarm_q);

  // R7: without a tick, a self-clearing alarm keeps its value
  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q && cfg_auto && !sec_tick |=> alarm_q);

endmodule

// File: rtl/lock_alarm_supervisor.sv
module lock_alarm_supervisor #(
  parameter int NUM_IN = 14,
  parameter int VAL_W  = 6,
  parameter int MUL_W  = 2,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              sel_valid,
  input  logic [SEL_W-1:0]  sel_idx,
  input  logic              pll_locked,
  input  logic [VAL_W-1:0]  cfg_val,
  input  logic [MUL_W-1:0]  cfg_mul,
  input  logic              cfg_auto_clr,
  input  logic              clr_we,
  input  logic [NUM_IN-1:0] clr_mask,
  output logic [NUM_IN-1:0] alarm,
  output logic [NUM_IN-1:0] disq
);
  localparam int LIM_W = VAL_W + MUL_W;

  logic [LIM_W-1:0]  limit;
  logic              expire;
  logic              restart;
  logic [NUM_IN-1:0] raise_vec;
  logic [NUM_IN-1:0] alarm_vec;

  assign limit = LIM_W'(lock_alarm_pkg::limit_of(32'(cfg_val), 32'(cfg_mul)));

  la_attempt_timer #(.SEL_W(SEL_W), .LIM_W(LIM_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .sel_valid  (sel_valid),
    .sel_idx    (sel_idx),
    .pll_locked (pll_locked),
    .limit      (limit),
    .expire     (expire),
    .restart    (restart)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_cell
    assign raise_vec[i] = expire && (sel_idx == SEL_W'(i));
    la_alarm_cell #(.LIM_W(LIM_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .limit    (limit),
      .cfg_auto (cfg_auto_clr),
      .raise    (raise_vec[i]),
      .clr_hit  (clr_we && clr_mask[i]),
      .alarm    (alarm_vec[i])
    );
  end

  assign alarm = alarm_vec;
  assign disq  = alarm_vec;

  // R5: at most one reference is raised per cycle, and only the selected one
  a_r5_single_raise: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(raise_vec));

  a_r5_raise_is_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vec != '0) |-> (sel_valid && !pll_locked));

  // R3: a restart cycle cannot expire unless a single second suffices
  a_r3_restart_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    restart && expire |-> (limit == LIM_W'(1)));

endmodule

// File: tb/lock_alarm_supervisor_tb.sv
module lock_alarm_supervisor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0;
  logic        sel_valid = 1'b0;
  logic [3:0]  sel_idx = '0;
  logic        pll_locked = 1'b0;
  logic [5:0]  cfg_val = '0;
  logic [1:0]  cfg_mul = '0;
  logic        cfg_auto_clr = 1'b0;
  logic        clr_we = 1'b0;
  logic [13:0] clr_mask = '0;
  logic [13:0] alarm, disq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lock_alarm_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sel_valid(sel_valid),
    .sel_idx(sel_idx), .pll_locked(pll_locked), .cfg_val(cfg_val),
    .cfg_mul(cfg_mul), .cfg_auto_clr(cfg_auto_clr), .clr_we(clr_we),
    .clr_mask(clr_mask), .alarm(alarm), .disq(disq)
  );

  // Bench model, phrased as "seconds seen in this attempt"
  int          m_secs;
  bit          m_spent;
  bit          m_pv;
  logic [3:0]  m_ps;
  logic [13:0] m_alarm;
  int          m_age [14];

  function automatic int bench_limit(input int v, input int m);
    int acc = 0;
    for (int k = 0; k < m; k++) acc += v;
    return acc;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_secs = 0; m_spent = 0; m_pv = 0; m_ps = '0; m_alarm = '0;
      for (int k = 0; k < 14; k++) m_age[k] = 0;
    end else begin
      int  lim;
      bit  fired;
      lim = bench_limit(int'(cfg_val), int'(cfg_mul));
      fired = 0;
      if (sel_valid && (!m_pv || sel_idx != m_ps)) begin
        m_secs = 0; m_spent = 0;
      end
      if (!sel_valid || pll_locked) begin
        m_secs = 0; m_spent = 0;
      end else if (sec_tick && !m_spent && lim != 0) begin
        m_secs++;
        if (m_secs >= lim) begin
          fired = 1; m_spent = 1; m_secs = 0;
        end
      end
      for (int k = 0; k < 14; k++) begin
        if (fired && int'(sel_idx) == k) begin
          m_alarm[k] = 1'b1; m_age[k] = 0;
        end else if (m_alarm[k]) begin
          if (cfg_auto_clr) begin
            if (sec_tick) begin
              m_age[k]++;
              if (m_age[k] >= lim) m_alarm[k] = 1'b0;
              else if (m_age[k] > 255) m_age[k] = 0;
            end
          end else if (clr_we && clr_mask[k]) begin
            m_alarm[k] = 1'b0;
          end
        end
      end
      m_pv = sel_valid; m_ps = sel_idx;
    end
  end

  task automatic check(input logic [13:0] act, input logic [13:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
    sec_tick = 1'b0; clr_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      sec_tick = 1'b1; cyc();
      cyc();
    end
  endtask

  task automatic pick(input int idx);
    sel_valid = 1'b1; sel_idx = 4'(idx); cyc();
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4711));
    @(negedge clk); cyc(); cyc();
    rst_n = 1'b1; cyc();
    // R11: reset state
    check(alarm, 14'h0, "R11 alarm after reset");
    check(disq, 14'h0, "R11 disq after reset");

    // R1, R9: manual policy, L = 3
    cfg_val = 6'd3; cfg_mul = 2'd1; cfg_auto_clr = 1'b0;
    pick(5);
    ticks(2);
    check(alarm, 14'h0, "R1 no alarm before limit");
    ticks(1);
    check(alarm, 14'h0020, "R1 alarm at limit on input 5");
    check(disq, 14'h0020, "R9 disq mirrors alarm");
    ticks(2);
    check(alarm, 14'h0020, "R10 held alarm");
    // R6: mask without bit 5, then with it
    clr_we = 1'b1; clr_mask = 14'h3FDF; cyc();
    check(alarm, 14'h0020, "R6 zero mask bit keeps alarm");
    clr_we = 1'b1; clr_mask = 14'h0020; cyc();
    check(alarm, 14'h0, "R6 one mask bit clears");
    // R10: same attempt does not raise again
    ticks(4);
    check(alarm, 14'h0, "R10 no re-raise in same attempt");

    // R3: reselection restarts the count
    pick(7); ticks(2);
    pick(8); ticks(2);
    check(alarm, 14'h0, "R3 old ticks not counted");
    ticks(1);
    check(alarm, 14'h0100, "R3 R5 alarm on input 8 only");
    clr_we = 1'b1; clr_mask = 14'h3FFF; cyc();

    // R2: lock on the expiring tick
    pick(2); ticks(2);
    pll_locked = 1'b1; sec_tick = 1'b1; cyc();
    check(alarm, 14'h0, "R2 lock wins on expiry tick");
    pll_locked = 1'b0; cyc();
    ticks(2);
    check(alarm, 14'h0, "R2 lock restarted timer");
    ticks(1);
    check(alarm, 14'h0004, "R2 alarm after lock lost");
    clr_we = 1'b1; clr_mask = 14'h0004; cyc();

    // R4: zero limit
    cfg_mul = 2'd0; pick(3); ticks(10);
    check(alarm, 14'h0, "R4 zero multiplier never alarms");
    cfg_mul = 2'd2; cfg_val = 6'd0; pick(4); ticks(6);
    check(alarm, 14'h0, "R4 zero value never alarms");

    // R7, R8: self-clearing, L = 2
    cfg_val = 6'd1; cfg_mul = 2'd2; cfg_auto_clr = 1'b1;
    pick(0); ticks(2);
    check(alarm, 14'h0001, "R7 alarm on input 0");
    pick(1); ticks(1);
    check(alarm, 14'h0001, "R7 input 0 ageing");
    ticks(1);
    check(alarm, 14'h0002, "R7 input 0 expired, input 1 raised");
    clr_we = 1'b1; clr_mask = 14'h3FFF; cyc();
    check(alarm, 14'h0002, "R8 write ignored in auto mode");
    ticks(1);
    check(alarm, 14'h0002, "R7 input 1 one tick old");
    ticks(1);
    check(alarm, 14'h0, "R7 input 1 expired");
    check(disq, 14'h0, "R9 disq cleared");

    // Random phase against the bench model (R1 R5 R6 R7 R9 R10)
    for (int c = 0; c < 4000; c++) begin
      sec_tick = ($urandom % 4) == 0;
      if (($urandom % 16) == 0) sel_idx = 4'($urandom % 14);
      sel_valid = ($urandom % 32) != 0;
      if (($urandom % 20) == 0) pll_locked = ~pll_locked;
      if (($urandom % 150) == 0) cfg_auto_clr = ~cfg_auto_clr;
      if (($urandom % 100) == 0) begin
        cfg_val = 6'($urandom % 5); cfg_mul = 2'($urandom % 4);
      end
      clr_we = ($urandom % 10) == 0;
      clr_mask = 14'($urandom);
      @(posedge clk); @(negedge clk);
      check(alarm, m_alarm, "R5 random alarm vs model");
      check(disq, m_alarm, "R9 random disq vs model");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule